// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides who owns a local processor bus: the internal bus sequencer or an external bus master. The external master asks for the bus by raising a hold request. The arbiter lets the current bus cycle, or a whole locked sequence, finish. It then turns off the internal address, data and status drivers, and only after that raises the hold acknowledge. When the external master drops its request, the arbiter lowers the acknowledge and turns the internal drivers back on after a dead time.

A pending memory refresh has first claim on the bus. While the internal side owns the bus, a refresh request keeps the bus from being handed over. While the external master owns the bus, a refresh request withdraws the acknowledge even though the external request is still high. The internal drivers then stay off until the external master has been seen to release its request. Only after that does arbitration resume, and the next request is served as a fresh one.

Multi-cycle transfers that must not be split, such as a four-cycle odd-to-odd word move, are presented to the arbiter as a locked sequence. The hold request input is asynchronous and passes through a synchronizer of `SYNC_STAGES` flops. `GAP_CYCLES` sets the dead time between the enable edge and the acknowledge edge.

Top module: `bushold_arbiter`

## Requirements
- R1: After reset, the hold acknowledge is 0, the bus output enable is 1 and the internal grant is 1.
- R2: When the bus is free, hold acknowledge rises exactly SYNC_STAGES+GAP_CYCLES+1 clock edges after the edge that first samples the request. A request that is withdrawn after one cycle produces no acknowledge, and the output enable returns to 1.
- R3: While a bus cycle is in progress (cycle_busy_i high), hold acknowledge is not given. It rises GAP_CYCLES+1 edges after cycle_busy_i falls.
- R4: While a locked sequence is active (lock_i high), hold acknowledge is not given. It rises GAP_CYCLES+1 edges after lock_i falls.
- R5: While refresh_req_i is high and the internal side owns the bus, hold acknowledge is not given. It rises GAP_CYCLES+1 edges after refresh_req_i falls.
- R6: Hold acknowledge and output enable are never 1 together. The enable falls GAP_CYCLES edges before the acknowledge rises.
- R7: When the request is removed, hold acknowledge falls SYNC_STAGES+1 edges later, and the output enable returns GAP_CYCLES edges after that.
- R8: refresh_req_i high while the acknowledge is given drops the acknowledge at the next edge, even with the request still high. The output enable stays 0 until the request has been observed low, and returns SYNC_STAGES+1+GAP_CYCLES edges after the request is removed.
- R9: The internal grant is 0 once a synchronized request is pending and neither lock_i nor refresh_req_i is high, and also whenever the internal side does not own the bus. It stays 1 during a pending request that is blocked by lock_i or refresh_req_i.
- R10: After a refresh withdrawal and release, a new request is acknowledged with the same latency as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Asynchronous bus request from the external master |
| refresh_req_i | input | 1 | Memory refresh needs the bus |
| cycle_busy_i | input | 1 | An internal bus cycle is in progress |
| lock_i | input | 1 | A locked or indivisible transfer sequence is in progress |
| hlda_o | output | 1 | Hold acknowledge to the external master |
| bus_oe_o | output | 1 | Enable for the internal address, data and status drivers |
| int_grant_o | output | 1 | The internal sequencer may start new cycles |

## Verification
The synchronizer and the gap counter make every result due a fixed number of edges after its stimulus. The acknowledge is due SYNC_STAGES+GAP_CYCLES+1 edges after a request on a free bus, and GAP_CYCLES+1 edges after a blocker clears. It falls SYNC_STAGES+1 edges after the request is released and one edge after a refresh while held. The bench drives inputs on the falling edge and steps one cycle at a time. At every step it compares all three outputs against a value computed from these counts, so an output that moves one edge early or late fails at that exact cycle. The blocker tests sweep the blocking duration and all three kinds of blocker.

// File: rtl/bha_pkg.sv
`timescale 1ns/1ps
package bha_pkg;
   typedef enum logic [2:0] {
      ARB_OWN   = 3'd0,
      ARB_REL   = 3'd1,
      ARB_HELD  = 3'd2,
      ARB_WDRAW = 3'd3,
      ARB_RET   = 3'd4
   } arb_state_t;
endpackage

// File: rtl/bha_sync.sv
`timescale 1ns/1ps
module bha_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("bha_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else if (i == 0) chain_q[i] <= async_i;
            else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bha_gap_timer.sv
`timescale 1ns/1ps
module bha_gap_timer #(
   parameter int GAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;

   generate
      if (GAP < 1) begin : g_bad_gap
         $error("bha_gap_timer: GAP must be at least 1");
      end
      if (GAP == 1) begin : g_single
         assign done_o = run_i;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else if (!run_i) cnt_q <= '0;
            else if (cnt_q != CW'(GAP-1)) cnt_q <= cnt_q + 1'b1;
            else cnt_q <= '0;
         end
         assign done_o = run_i && (cnt_q == CW'(GAP-1));
      end
   endgenerate
endmodule

// File: rtl/bha_fsm.sv
`timescale 1ns/1ps
module bha_fsm
   import bha_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_s_i,
   input  logic       refresh_req_i,
   input  logic       cycle_busy_i,
   input  logic       lock_i,
   input  logic       gap_done_i,
   output logic       gap_run_o,
   output logic       hlda_o,
   output logic       bus_oe_o,
   output logic       int_grant_o
);
   arb_state_t state_q, state_d;
   logic       handover;

   // Refresh outranks the external request; a cycle or locked run must end first.
   assign handover = hold_s_i && !refresh_req_i && !cycle_busy_i && !lock_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_OWN:   if (handover) state_d = ARB_REL;
         ARB_REL:   if (gap_done_i)
                       state_d = (hold_s_i && !refresh_req_i) ? ARB_HELD : ARB_OWN;
         ARB_HELD:  if (!hold_s_i) state_d = ARB_RET;
                    else if (refresh_req_i) state_d = ARB_WDRAW;
         ARB_WDRAW: if (!hold_s_i) state_d = ARB_RET;
         ARB_RET:   if (gap_done_i) state_d = ARB_OWN;
         default:   state_d = ARB_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_OWN;
      else        state_q <= state_d;
   end

   assign gap_run_o   = (state_q == ARB_REL) || (state_q == ARB_RET);
   assign hlda_o      = (state_q == ARB_HELD);
   assign bus_oe_o    = (state_q == ARB_OWN);
   assign int_grant_o = (state_q == ARB_OWN) &&
                        !(hold_s_i && !refresh_req_i && !lock_i);

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hlda_o && bus_oe_o));
   p_oe_before_hlda_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda_o) |-> !$past(bus_oe_o));
   p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe_o && cycle_busy_i) |=> bus_oe_o);
   p_lock_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe_o && lock_i) |=> bus_oe_o);
   p_refresh_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe_o && refresh_req_i) |=> bus_oe_o);
   p_withdraw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hlda_o && refresh_req_i) |=> !hlda_o);
   p_no_drive_until_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hlda_o && !bus_oe_o && hold_s_i && $past(hlda_o)) |=> !bus_oe_o);
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hlda_o && !hold_s_i) |=> !hlda_o);
endmodule

// File: rtl/bushold_arbiter.sv
`timescale 1ns/1ps
module bushold_arbiter #(
   parameter int SYNC_STAGES = 2,
   parameter int GAP_CYCLES  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic refresh_req_i,
   input  logic cycle_busy_i,
   input  logic lock_i,
   output logic hlda_o,
   output logic bus_oe_o,
   output logic int_grant_o
);
   logic hold_s;
   logic gap_run, gap_done;

   bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (hold_i),
      .sync_o  (hold_s)
   );

   bha_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (gap_run),
      .done_o (gap_done)
   );

   bha_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .hold_s_i      (hold_s),
      .refresh_req_i (refresh_req_i),
      .cycle_busy_i  (cycle_busy_i),
      .lock_i        (lock_i),
      .gap_done_i    (gap_done),
      .gap_run_o     (gap_run),
      .hlda_o        (hlda_o),
      .bus_oe_o      (bus_oe_o),
      .int_grant_o   (int_grant_o)
   );
endmodule

// File: tb/tb_bushold_arbiter.sv
`timescale 1ns/1ps
module tb_bushold_arbiter;
   localparam int S = 2;
   localparam int G = 1;
   localparam int L = S + G + 1;

   logic clk = 1'b0;
   logic rst_n, hold, refresh, busy, lock;
   logic hlda, oe, grant;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bushold_arbiter #(.SYNC_STAGES(S), .GAP_CYCLES(G)) dut (
      .clk(clk), .rst_n(rst_n), .hold_i(hold), .refresh_req_i(refresh),
      .cycle_busy_i(busy), .lock_i(lock),
      .hlda_o(hlda), .bus_oe_o(oe), .int_grant_o(grant)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk("R6", "acknowledge and enable both high", hlda && oe, 1'b0);
      end
   endtask

   task automatic release_bus();
      hold = 1'b0;
      step(S + G + 3);
      chk("R7", "enable restored", oe, 1'b1);
   endtask

   // kind 0: busy cycle (R3), 1: lock (R4), 2: refresh (R5)
   task automatic blocked(input int kind, input int dur);
      string tag;
      tag = (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R5";
      busy = (kind == 0); lock = (kind == 1); refresh = (kind == 2);
      hold = 1'b1;
      for (int k = 1; k <= S + dur + 1; k++) begin
         step(1);
         chk(tag, "acknowledge while blocked", hlda, 1'b0);
         chk(tag, "enable while blocked", oe, 1'b1);
      end
      chk("R9", "grant with blocked request", grant, (kind == 0) ? 1'b0 : 1'b1);
      busy = 1'b0; lock = 1'b0; refresh = 1'b0;
      for (int k = 1; k <= G + 1; k++) begin
         step(1);
         chk(tag, "acknowledge after blocker clears", hlda, (k == G + 1));
      end
      release_bus();
   endtask

   initial begin
      rst_n = 1'b0; hold = 1'b0; refresh = 1'b0; busy = 1'b0; lock = 1'b0;
      step(3);
      chk("R1", "acknowledge in reset", hlda, 1'b0);
      chk("R1", "enable in reset", oe, 1'b1);
      rst_n = 1'b1;
      step(2);
      chk("R1", "acknowledge after reset", hlda, 1'b0);
      chk("R1", "enable after reset", oe, 1'b1);
      chk("R1", "grant after reset", grant, 1'b1);

      // R2 latency, R6 enable ordering, R9 grant drop
      hold = 1'b1;
      for (int k = 1; k <= L + 1; k++) begin
         step(1);
         chk("R2", "acknowledge latency", hlda, (k >= L));
         chk("R6", "enable before acknowledge", oe, (k <= S));
         chk("R9", "grant on pending request", grant, (k < S));
      end
      // R7 release timing
      hold = 1'b0;
      for (int k = 1; k <= S + G + 2; k++) begin
         step(1);
         chk("R7", "acknowledge fall", hlda, (k <= S));
         chk("R7", "enable return", oe, (k >= S + 1 + G));
      end

      for (int kind = 0; kind < 3; kind++)
         for (int d = 1; d <= 4; d++)
            blocked(kind, d);

      // R8 refresh withdrawal while held
      hold = 1'b1;
      step(L);
      chk("R8", "acknowledge before refresh", hlda, 1'b1);
      refresh = 1'b1;
      step(1);
      chk("R8", "acknowledge withdrawn", hlda, 1'b0);
      chk("R8", "enable after withdrawal", oe, 1'b0);
      refresh = 1'b0;
      for (int k = 0; k < 6; k++) begin
         step(1);
         chk("R8", "acknowledge with request still high", hlda, 1'b0);
         chk("R8", "enable with request still high", oe, 1'b0);
         chk("R9", "grant while not owning", grant, 1'b0);
      end
      hold = 1'b0;
      for (int k = 1; k <= S + 1 + G; k++) begin
         step(1);
         chk("R8", "enable after request low", oe, (k == S + 1 + G));
      end

      // R10 re-request after withdrawal
      hold = 1'b1;
      step(L - 1);
      chk("R10", "acknowledge one cycle early", hlda, 1'b0);
      step(1);
      chk("R10", "acknowledge on re-request", hlda, 1'b1);
      release_bus();

      // R2 short pulse gives no acknowledge
      hold = 1'b1;
      step(1);
      hold = 1'b0;
      for (int k = 0; k < 8; k++) begin
         step(1);
         chk("R2", "acknowledge on short pulse", hlda, 1'b0);
      end
      chk("R2", "enable after short pulse", oe, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule